// File: doc/BRIEF.md
# ASID-Tagged Fully Associative TLB

This block is a small translation cache that maps virtual page numbers to physical page numbers plus an attribute field. Every entry is compared in parallel against the incoming virtual page, so a lookup answers with hit, physical page and attributes combinationally, in the same cycle as the request. Entries can be global, or non-global and tagged with the address space identifier (ASID) that was current when they were installed. Several non-global translations of one virtual page can therefore live side by side for different address spaces, and switching the current ASID needs no flush.

When a valid lookup finds nothing, the block raises a miss request toward a next-level translation source. The request carries the virtual page and the current ASID. A fill port installs the answer. Fill placement never leaves two entries that could answer the same lookup. An invalidate port drops every entry, the non-global entries of one ASID, or every entry for one virtual page.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so every valid lookup misses.
- R2: A lookup with `lkp_valid_i` high returns `lkp_hit_o`, `lkp_ppn_o` and `lkp_attr_o` in the same cycle. A global entry (installed with `fill_nglobal_i`=0) hits for any `cur_asid_i`.
- R3: A non-global entry stores the `cur_asid_i` value present at its fill. It hits only when both the virtual page and `cur_asid_i` equal the stored values. A change of `cur_asid_i` applies to the very next lookup.
- R4: Non-global entries for one virtual page with different ASIDs coexist, and each returns its own physical page.
- R5: A valid lookup that misses drives `miss_req_o`=1 in the same cycle, with `miss_vpn_o`=`lkp_vpn_i` and `miss_asid_o`=`cur_asid_i`.
- R6: Two valid entries overlap when they have the same virtual page and either is global or both carry the same ASID. A fill that overlaps existing entries rewrites the lowest-index one and invalidates the others. At no time do two valid entries match one lookup.
- R7: A fill that overlaps nothing picks a slot as follows. It takes the first invalid entry found while scanning upward, with wrap, from a round-robin pointer. If no entry is invalid, it takes the pointer's entry. The pointer then moves to the chosen index plus one, modulo the entry count. The pointer is 0 after reset.
- R8: Invalidate with `inv_op_i`=2'b00 clears all entries.
- R9: Invalidate with `inv_op_i`=2'b01 clears only non-global entries whose ASID equals `inv_asid_i`. Global entries stay.
- R10: Invalidate with `inv_op_i`=2'b10 clears every entry whose virtual page equals `inv_vpn_i`, whatever its ASID. `inv_op_i`=2'b11 changes nothing.
- R11: When `inv_valid_i` and `fill_valid_i` are high in the same cycle, the invalidate is applied and the fill is dropped.
- R12: With `lkp_valid_i` low, `lkp_hit_o` and `miss_req_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Lookup virtual page |
| cur_asid_i | input | ASID_W | Current address space identifier |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_ppn_o | output | PPN_W | Physical page on hit, else 0 |
| lkp_attr_o | output | ATTR_W | Attributes on hit, else 0 |
| miss_req_o | output | 1 | Miss request to next level |
| miss_vpn_o | output | VPN_W | Virtual page of the miss |
| miss_asid_o | output | ASID_W | ASID of the miss |
| fill_valid_i | input | 1 | Install an entry |
| fill_vpn_i | input | VPN_W | Virtual page to install |
| fill_ppn_i | input | PPN_W | Physical page to install |
| fill_attr_i | input | ATTR_W | Attributes to install |
| fill_nglobal_i | input | 1 | 1: non-global, tagged with cur_asid_i |
| inv_valid_i | input | 1 | Invalidate request |
| inv_op_i | input | 2 | 00 all, 01 by ASID, 10 by page, 11 none |
| inv_asid_i | input | ASID_W | ASID for invalidate by ASID |
| inv_vpn_i | input | VPN_W | Page for invalidate by page |

## Verification
The assertions watch four things on every cycle:
- at most one entry matches the current lookup;
- a miss is forwarded with the lookup's page and ASID;
- a lookup idles quietly when it is not valid;
- a full invalidate empties the table, and a fill is visible to a matching lookup one cycle later.

Other behaviour only shows up across sequences of operations, and the bench's scenarios cover it:
- victim choice by the round-robin pointer, including eviction when the table is full;
- coexistence of per-ASID entries;
- selective invalidation by ASID and by page;
- dropping of a fill that collides with an invalidate.

A long mixed sweep over a narrow page and ASID range compares every lookup with an arithmetic model.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  typedef enum logic [1:0] {
    INV_ALL  = 2'b00,
    INV_ASID = 2'b01,
    INV_VPN  = 2'b10,
    INV_NONE = 2'b11
  } inv_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0]             ng_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab_i,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_tab_i,
  input  logic [VPN_W-1:0]               vpn_i,
  input  logic [ASID_W-1:0]              asid_i,
  input  logic                           any_asid_i,
  output logic [ENTRIES-1:0]             match_o,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               idx_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_tab_i[g] == vpn_i) &&
                        (!ng_i[g] || any_asid_i || (asid_tab_i[g] == asid_i));
  end

  assign hit_o = |match_o;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   ptr_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic found;

  always_comb begin
    victim_o = ptr_i;
    found    = 1'b0;
    for (int unsigned k = 0; k < ENTRIES; k++) begin
      int unsigned j;
      j = (int'(ptr_i) + k) % ENTRIES;
      if (!found && !valid_i[j]) begin
        victim_o = IDX_W'(j);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 24,
  parameter int unsigned ATTR_W  = 6,
  parameter int unsigned ASID_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  output logic              lkp_hit_o,
  output logic [PPN_W-1:0]  lkp_ppn_o,
  output logic [ATTR_W-1:0] lkp_attr_o,
  output logic              miss_req_o,
  output logic [VPN_W-1:0]  miss_vpn_o,
  output logic [ASID_W-1:0] miss_asid_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [ATTR_W-1:0] fill_attr_i,
  input  logic              fill_nglobal_i,
  input  logic              inv_valid_i,
  input  logic [1:0]        inv_op_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic [VPN_W-1:0]  inv_vpn_i
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0]             ng_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0][ATTR_W-1:0] attr_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [IDX_W-1:0]               rr_q;

  logic [ENTRIES-1:0] lkp_match, ovl_match, kill;
  logic               lkp_any, ovl_any, fill_go;
  logic [IDX_W-1:0]   lkp_idx, ovl_idx, victim_idx, tgt_idx;
  inv_op_e            inv_op;

  assign inv_op  = inv_op_e'(inv_op_i);
  assign fill_go = fill_valid_i && !inv_valid_i;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lkp_match (
    .valid_i    (valid_q),
    .ng_i       (ng_q),
    .vpn_tab_i  (vpn_q),
    .asid_tab_i (asid_q),
    .vpn_i      (lkp_vpn_i),
    .asid_i     (cur_asid_i),
    .any_asid_i (1'b0),
    .match_o    (lkp_match),
    .hit_o      (lkp_any),
    .idx_o      (lkp_idx)
  );

  // overlap search for a fill: a global fill collides with any ASID
  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_ovl_match (
    .valid_i    (valid_q),
    .ng_i       (ng_q),
    .vpn_tab_i  (vpn_q),
    .asid_tab_i (asid_q),
    .vpn_i      (fill_vpn_i),
    .asid_i     (cur_asid_i),
    .any_asid_i (!fill_nglobal_i),
    .match_o    (ovl_match),
    .hit_o      (ovl_any),
    .idx_o      (ovl_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_i  (valid_q),
    .ptr_i    (rr_q),
    .victim_o (victim_idx)
  );

  assign tgt_idx = ovl_any ? ovl_idx : victim_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
    always_comb begin
      case (inv_op)
        INV_ALL:  kill[g] = 1'b1;
        INV_ASID: kill[g] = ng_q[g] && (asid_q[g] == inv_asid_i);
        INV_VPN:  kill[g] = (vpn_q[g] == inv_vpn_i);
        default:  kill[g] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (inv_valid_i) begin
      valid_q <= valid_q & ~kill;
    end else if (fill_go) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ovl_match[i] && (IDX_W'(i) != tgt_idx)) valid_q[i] <= 1'b0;
      end
      valid_q[tgt_idx] <= 1'b1;
      if (!ovl_any) begin
        rr_q <= (victim_idx == IDX_W'(ENTRIES - 1)) ? '0 : victim_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_go) begin
      ng_q[tgt_idx]   <= fill_nglobal_i;
      vpn_q[tgt_idx]  <= fill_vpn_i;
      ppn_q[tgt_idx]  <= fill_ppn_i;
      attr_q[tgt_idx] <= fill_attr_i;
      asid_q[tgt_idx] <= fill_nglobal_i ? cur_asid_i : '0;
    end
  end

  assign lkp_hit_o   = lkp_valid_i && lkp_any;
  assign lkp_ppn_o   = lkp_hit_o ? ppn_q[lkp_idx] : '0;
  assign lkp_attr_o  = lkp_hit_o ? attr_q[lkp_idx] : '0;
  assign miss_req_o  = lkp_valid_i && !lkp_any;
  assign miss_vpn_o  = lkp_vpn_i;
  assign miss_asid_o = cur_asid_i;
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 24,
  parameter int unsigned ASID_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lkp_valid_i,
  input logic [VPN_W-1:0]   lkp_vpn_i,
  input logic [ASID_W-1:0]  cur_asid_i,
  input logic               lkp_hit_o,
  input logic [PPN_W-1:0]   lkp_ppn_o,
  input logic               miss_req_o,
  input logic [VPN_W-1:0]   miss_vpn_o,
  input logic [ASID_W-1:0]  miss_asid_o,
  input logic               fill_valid_i,
  input logic [VPN_W-1:0]   fill_vpn_i,
  input logic [PPN_W-1:0]   fill_ppn_i,
  input logic               inv_valid_i,
  input logic [1:0]         inv_op_i,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] lkp_match
);
  p_single_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lkp_match) <= 1);

  p_miss_fwd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && !lkp_hit_o) |->
      (miss_req_o && miss_vpn_o == lkp_vpn_i && miss_asid_o == cur_asid_i));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |-> (!lkp_hit_o && !miss_req_o));

  p_inv_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && inv_op_i == 2'b00) |=> (valid_q == '0));

  p_fill_visible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !inv_valid_i) |=>
      (!(lkp_valid_i && lkp_vpn_i == $past(fill_vpn_i) && cur_asid_i == $past(cur_asid_i))
       || (lkp_hit_o && lkp_ppn_o == $past(fill_ppn_i))));
endmodule

bind asid_tlb asid_tlb_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lkp_valid_i  (lkp_valid_i),
  .lkp_vpn_i    (lkp_vpn_i),
  .cur_asid_i   (cur_asid_i),
  .lkp_hit_o    (lkp_hit_o),
  .lkp_ppn_o    (lkp_ppn_o),
  .miss_req_o   (miss_req_o),
  .miss_vpn_o   (miss_vpn_o),
  .miss_asid_o  (miss_asid_o),
  .fill_valid_i (fill_valid_i),
  .fill_vpn_i   (fill_vpn_i),
  .fill_ppn_i   (fill_ppn_i),
  .inv_valid_i  (inv_valid_i),
  .inv_op_i     (inv_op_i),
  .valid_q      (valid_q),
  .lkp_match    (lkp_match)
);

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;
  localparam int N  = 32;
  localparam int VW = 20;
  localparam int PW = 24;
  localparam int AW = 6;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          lkp_valid = 0;
  logic [VW-1:0] lkp_vpn = '0;
  logic [SW-1:0] cur_asid = '0;
  logic          hit, miss_req;
  logic [PW-1:0] ppn;
  logic [AW-1:0] attr;
  logic [VW-1:0] miss_vpn;
  logic [SW-1:0] miss_asid;
  logic          fill_valid = 0, fill_ng = 0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic [AW-1:0] fill_attr = '0;
  logic          inv_valid = 0;
  logic [1:0]    inv_op = '0;
  logic [SW-1:0] inv_asid = '0;
  logic [VW-1:0] inv_vpn = '0;

  asid_tlb dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_vpn_i(lkp_vpn), .cur_asid_i(cur_asid),
    .lkp_hit_o(hit), .lkp_ppn_o(ppn), .lkp_attr_o(attr),
    .miss_req_o(miss_req), .miss_vpn_o(miss_vpn), .miss_asid_o(miss_asid),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .fill_attr_i(fill_attr), .fill_nglobal_i(fill_ng),
    .inv_valid_i(inv_valid), .inv_op_i(inv_op), .inv_asid_i(inv_asid), .inv_vpn_i(inv_vpn)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference table
  bit            m_v[N];
  bit            m_ng[N];
  logic [VW-1:0] m_vpn[N];
  logic [PW-1:0] m_ppn[N];
  logic [AW-1:0] m_attr[N];
  logic [SW-1:0] m_asid[N];
  int            m_rr = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_find(logic [VW-1:0] v, logic [SW-1:0] a);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == v && (!m_ng[i] || m_asid[i] == a)) return i;
    return -1;
  endfunction

  task automatic m_fill(logic [VW-1:0] v, logic [PW-1:0] p, logic [AW-1:0] t, bit ng, logic [SW-1:0] a);
    int tgt;
    tgt = -1;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == v && (!m_ng[i] || !ng || m_asid[i] == a)) begin
        if (tgt < 0) tgt = i; else m_v[i] = 0;
      end
    if (tgt < 0) begin
      tgt = m_rr;
      for (int k = N - 1; k >= 0; k--)
        if (!m_v[(m_rr + k) % N]) tgt = (m_rr + k) % N;
      m_rr = (tgt + 1) % N;
    end
    m_v[tgt] = 1; m_ng[tgt] = ng; m_vpn[tgt] = v; m_ppn[tgt] = p;
    m_attr[tgt] = t; m_asid[tgt] = ng ? a : '0;
  endtask

  task automatic m_inv(logic [1:0] op, logic [SW-1:0] a, logic [VW-1:0] v);
    for (int i = 0; i < N; i++)
      case (op)
        2'b00: m_v[i] = 0;
        2'b01: if (m_ng[i] && m_asid[i] == a) m_v[i] = 0;
        2'b10: if (m_vpn[i] == v) m_v[i] = 0;
        default: ;
      endcase
  endtask

  task automatic do_fill(logic [VW-1:0] v, logic [PW-1:0] p, logic [AW-1:0] t, bit ng, logic [SW-1:0] a);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_attr = t; fill_ng = ng; cur_asid = a;
    @(negedge clk);
    fill_valid = 0;
    m_fill(v, p, t, ng, a);
  endtask

  task automatic do_inv(logic [1:0] op, logic [SW-1:0] a, logic [VW-1:0] v);
    @(negedge clk);
    inv_valid = 1; inv_op = op; inv_asid = a; inv_vpn = v;
    @(negedge clk);
    inv_valid = 0;
    m_inv(op, a, v);
  endtask

  task automatic lookup(logic [VW-1:0] v, logic [SW-1:0] a, string req);
    int e;
    @(negedge clk);
    lkp_valid = 1; lkp_vpn = v; cur_asid = a;
    #1;
    e = m_find(v, a);
    chk(hit == (e >= 0), req, hit, e >= 0);
    if (e >= 0) begin
      chk(ppn == m_ppn[e] && attr == m_attr[e], req, {ppn, attr}, {m_ppn[e], m_attr[e]});
    end else begin
      chk(miss_req && miss_vpn == v && miss_asid == a, {req, " R5"},
          {miss_req, miss_vpn, miss_asid}, {1'b1, v, a});
    end
    lkp_valid = 0;
  endtask

  // direct expectation, not through the model
  task automatic expect_hit(logic [VW-1:0] v, logic [SW-1:0] a, bit exp_hit, logic [PW-1:0] exp_ppn, string req);
    @(negedge clk);
    lkp_valid = 1; lkp_vpn = v; cur_asid = a;
    #1;
    chk(hit == exp_hit, req, hit, exp_hit);
    if (exp_hit) chk(ppn == exp_ppn, req, ppn, exp_ppn);
    lkp_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int v = 0; v < 8; v++) expect_hit(VW'(v), 8'h00, 0, '0, "R1");

    // R12 idle lookup
    @(negedge clk); lkp_valid = 0; lkp_vpn = '0; #1;
    chk(!hit && !miss_req, "R12", {hit, miss_req}, 0);

    // R2 R7 fill all 32 global, then evict at pointer 0
    for (int i = 0; i < N; i++) do_fill(VW'(32'h40 + i), PW'(32'h1000 + i), AW'(i), 0, 8'h00);
    for (int i = 0; i < N; i++) expect_hit(VW'(32'h40 + i), 8'h33, 1, PW'(32'h1000 + i), "R2");
    do_fill(VW'(32'h80), PW'(32'h2080), 6'h3, 0, 8'h00);
    expect_hit(VW'(32'h40), 8'h00, 0, '0, "R7 evict ptr0");
    expect_hit(VW'(32'h80), 8'h00, 1, PW'(32'h2080), "R7");
    expect_hit(VW'(32'h41), 8'h00, 1, PW'(32'h1001), "R7");
    do_inv(2'b10, 8'h00, VW'(32'h45));
    do_fill(VW'(32'h81), PW'(32'h2081), 6'h4, 0, 8'h00);
    expect_hit(VW'(32'h41), 8'h00, 1, PW'(32'h1001), "R7 invalid first");
    expect_hit(VW'(32'h81), 8'h00, 1, PW'(32'h2081), "R7");

    // R8
    do_inv(2'b00, 8'h00, '0);
    for (int i = 0; i < 4; i++) expect_hit(VW'(32'h41 + i), 8'h00, 0, '0, "R8");

    // R3 R4 coexisting ASIDs
    do_fill(VW'(32'h100), PW'(32'hA00), 6'h1, 1, 8'h05);
    do_fill(VW'(32'h100), PW'(32'hB00), 6'h2, 1, 8'h09);
    do_fill(VW'(32'h200), PW'(32'hC00), 6'h3, 0, 8'h05);
    expect_hit(VW'(32'h100), 8'h05, 1, PW'(32'hA00), "R4");
    expect_hit(VW'(32'h100), 8'h09, 1, PW'(32'hB00), "R4");
    expect_hit(VW'(32'h100), 8'h07, 0, '0, "R3");
    expect_hit(VW'(32'h200), 8'h07, 1, PW'(32'hC00), "R2");

    // R9
    do_inv(2'b01, 8'h05, '0);
    expect_hit(VW'(32'h100), 8'h05, 0, '0, "R9");
    expect_hit(VW'(32'h100), 8'h09, 1, PW'(32'hB00), "R9");
    expect_hit(VW'(32'h200), 8'h05, 1, PW'(32'hC00), "R9 global kept");

    // R10 no-op code, then by page
    do_inv(2'b11, 8'h09, VW'(32'h100));
    expect_hit(VW'(32'h100), 8'h09, 1, PW'(32'hB00), "R10 nop");
    do_inv(2'b10, 8'h00, VW'(32'h100));
    expect_hit(VW'(32'h100), 8'h09, 0, '0, "R10");

    // R6 global fill replaces per-ASID copies
    do_fill(VW'(32'h300), PW'(32'hD01), 6'h1, 1, 8'h01);
    do_fill(VW'(32'h300), PW'(32'hD02), 6'h1, 1, 8'h02);
    do_fill(VW'(32'h300), PW'(32'hE00), 6'h2, 0, 8'h01);
    expect_hit(VW'(32'h300), 8'h02, 1, PW'(32'hE00), "R6");
    do_fill(VW'(32'h300), PW'(32'hE11), 6'h2, 0, 8'h00);
    expect_hit(VW'(32'h300), 8'h01, 1, PW'(32'hE11), "R6 rewrite");

    // R11 fill dropped under invalidate
    @(negedge clk);
    fill_valid = 1; fill_vpn = VW'(32'h400); fill_ppn = PW'(32'hF00); fill_ng = 0;
    inv_valid = 1; inv_op = 2'b10; inv_vpn = VW'(32'h999);
    @(negedge clk);
    fill_valid = 0; inv_valid = 0;
    m_inv(2'b10, 8'h00, VW'(32'h999));
    expect_hit(VW'(32'h400), 8'h00, 0, '0, "R11");

    // mixed sweep against model
    lfsr = 16'hACE1;
    for (int r = 0; r < 220; r++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[9:7] == 3'd0)
        do_inv(lfsr[11:10], SW'(lfsr[5:4]), VW'(lfsr[3:0]));
      else
        do_fill(VW'(lfsr[3:0]), PW'({lfsr, 8'(r)}), AW'(lfsr[15:10]), lfsr[6], SW'(lfsr[5:4]));
      for (int v = 0; v < 16; v++)
        for (int a = 0; a < 4; a++) lookup(VW'(v), SW'(a), "R6 sweep");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule